// File: doc/BRIEF.md
# Serial Clock and Chip-Select Timing Generator

This block sits between a flash sequencer and the pins of a four-wire-select serial flash bus. From the reference clock it derives the serial clock and drives the four chip-select lines. Every delay is counted in reference clock cycles. The serial clock has a programmable divisor, an idle level and a phase. The chip-select timing has four programmable intervals: setup before the first clock edge, hold after the last edge, a minimum released time between frames, and a longer released time that applies when the next frame targets a different device. Shifting data is left to the sequencer, which counts serial clock edges on its own.

A frame follows a level handshake. The sequencer raises `frm_req`. The block pulls chip select low, waits the setup interval and then raises `frm_ack`. While `frm_ack` is high the serial clock runs. The sequencer lowers `frm_req` to end the frame. The block parks the clock at its idle level, drops `frm_ack`, waits the hold interval and releases chip select. Polarity, phase, divisor, output mode and device selection are copied from the configuration inputs only while the enable input is low and no frame is open. The delay inputs are used live.

Top module: `qspi_cs_timer`

## Requirements
- R1: After reset `cs_n` is 4'hF, `sclk` is 0, `frm_ack` is 0 and `idle` is 1.
- R2: In direct mode (`cfg_dec`=0), the selection field during a frame is bits 1:0 of `cfg_sel` = n, and `cs_n` is 4'hF with bit n cleared. The upper selection bits are ignored.
- R3: In decoder mode (`cfg_dec`=1), `cs_n` carries the raw 4-bit `cfg_sel` code during a frame. Outside a frame `cs_n` is 4'hF in both modes.
- R4: After `frm_req` is seen, chip select falls, and `frm_ack` rises max(`dly_setup`,1) cycles later.
- R5: While no frame is running, `sclk` equals the latched polarity. While `frm_ack` is high, `sclk` changes level every N+1 cycles, where N is the latched divisor, so the period is 2(N+1) cycles.
- R6: The first `sclk` change comes 1 cycle after `frm_ack` rises when phase is 1, and N+1 cycles after it rises when phase is 0.
- R7: After `frm_req` falls, the frame ends on the first edge at which `sclk` is at its idle level. `frm_ack` falls on that edge and `sclk` stays at the idle level from then on.
- R8: Chip select is released max(`dly_hold`,1) cycles after `frm_ack` falls.
- R9: When the next frame targets the same device, chip select stays high for exactly max(`dly_minhi`,1) cycles while a request is waiting. `dly_d2d` has no effect in this case.
- R10: When the output pattern of the next frame differs from the previous one, chip select stays high for at least max(`dly_minhi`,`dly_d2d`,1) cycles.
- R11: A frame starts only while `cfg_en` is 1. The configuration inputs are copied only while `cfg_en` is 0 and no frame is open. Changes made while enabled have no effect.
- R12: `idle` is 1 only when no frame is open and the released-time interval required for the current selection has elapsed. During a frame it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enable; configuration is copied while low |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Serial clock phase |
| cfg_dec | input | 1 | 1: raw code for an external decoder, 0: direct active-low select |
| cfg_sel | input | 4 | Device selection field |
| cfg_div | input | 4 | Divisor N; half period is N+1 cycles |
| dly_setup | input | 8 | Chip-select low to first clock interval |
| dly_hold | input | 8 | Last clock to chip-select high interval |
| dly_d2d | input | 8 | Released time when the device changes |
| dly_minhi | input | 8 | Minimum released time |
| frm_req | input | 1 | Frame request from the sequencer |
| frm_ack | output | 1 | Frame running, serial clock active |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Chip-select lines or decoder code |
| idle | output | 1 | No frame open and the released time has elapsed |

## Verification
The hardest case to reach is the released-time rule when the device changes. The selection can only change while the block is disabled and no frame is open, yet the released time must be measured while a request is already waiting. The stimulus keeps `frm_req` high through the hold interval. On the first cycle chip select is high it lowers `cfg_en` and loads a new selection, and it re-enables on the next cycle. This gives an exact count of released cycles for same-device and changed-device pairs, including the case where `dly_minhi` is the larger interval.

// File: rtl/qct_pkg.sv
package qct_pkg;
  // Frame sequencing states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2,
    ST_HOLD  = 2'd3
  } qct_state_e;
endpackage

// File: rtl/qct_shadow.sv
module qct_shadow #(
  parameter int SEL_W = 4,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             dec_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             cpol_q,
  output logic             cpha_q,
  output logic             dec_q,
  output logic [SEL_W-1:0] sel_q,
  output logic [DIV_W-1:0] div_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      dec_q  <= 1'b0;
      sel_q  <= '0;
      div_q  <= '0;
    end else if (load) begin
      cpol_q <= cpol_i;
      cpha_q <= cpha_i;
      dec_q  <= dec_i;
      sel_q  <= sel_i;
      div_q  <= div_i;
    end
  end
endmodule

// File: rtl/qct_sclk.sv
module qct_sclk #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick_en,
  input  logic             cpha,
  input  logic [DIV_W-1:0] div,
  output logic             ph
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             ph_q, ph_d;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (start) begin
      // phase 1 preloads the counter so the first change comes at once
      cnt_d = cpha ? div : '0;
      ph_d  = 1'b0;
    end else if (tick_en) begin
      if (cnt_q == div) begin
        cnt_d = '0;
        ph_d  = ~ph_q;
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end else begin
      ph_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign ph = ph_q;
endmodule

// File: rtl/qct_cs_enc.sv
module qct_cs_enc #(
  parameter int SEL_W = 4
) (
  input  logic             active,
  input  logic             dec,
  input  logic [SEL_W-1:0] sel,
  output logic [SEL_W-1:0] pat,
  output logic [SEL_W-1:0] cs_n
);
  localparam int IDX_W = (SEL_W > 1) ? $clog2(SEL_W) : 1;

  logic [SEL_W-1:0] direct_n;

  for (genvar g = 0; g < SEL_W; g++) begin : g_line
    assign direct_n[g] = (sel[IDX_W-1:0] != IDX_W'(g));
  end

  assign pat  = dec ? sel : direct_n;
  assign cs_n = active ? pat : '1;
endmodule

// File: rtl/qct_fsm.sv
module qct_fsm
  import qct_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             req,
  input  logic             ph,
  input  logic [SEL_W-1:0] pat,
  input  logic [DLY_W-1:0] d_setup,
  input  logic [DLY_W-1:0] d_hold,
  input  logic [DLY_W-1:0] d_d2d,
  input  logic [DLY_W-1:0] d_minhi,
  output qct_state_e       st,
  output logic             run_start,
  output logic             tick_en,
  output logic             ack,
  output logic             idle
);
  localparam int HW = DLY_W + 1;

  qct_state_e       st_q, st_d;
  logic [DLY_W-1:0] dcnt_q, dcnt_d;
  logic [HW-1:0]    hi_q, hi_d;
  logic [SEL_W-1:0] last_q, last_d;
  logic [DLY_W-1:0] gap_need;
  logic             gap_ok;
  logic             stop;

  // released time: the larger interval applies when the pattern changes
  always_comb begin
    gap_need = d_minhi;
    if ((pat != last_q) && (d_d2d > d_minhi)) gap_need = d_d2d;
  end

  assign gap_ok = (hi_q >= {1'b0, gap_need});
  assign stop   = !req && !ph;

  always_comb begin
    st_d      = st_q;
    dcnt_d    = dcnt_q;
    hi_d      = hi_q;
    last_d    = last_q;
    run_start = 1'b0;
    tick_en   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (hi_q != '1) hi_d = hi_q + HW'(1);
        if (en && req && gap_ok) begin
          st_d   = ST_SETUP;
          dcnt_d = d_setup;
          last_d = pat;
        end
      end
      ST_SETUP: begin
        if (dcnt_q <= DLY_W'(1)) begin
          st_d      = ST_RUN;
          run_start = 1'b1;
        end else begin
          dcnt_d = dcnt_q - DLY_W'(1);
        end
      end
      ST_RUN: begin
        if (stop) begin
          st_d   = ST_HOLD;
          dcnt_d = d_hold;
        end else begin
          tick_en = 1'b1;
        end
      end
      ST_HOLD: begin
        if (dcnt_q <= DLY_W'(1)) begin
          st_d = ST_IDLE;
          hi_d = HW'(1);
        end else begin
          dcnt_d = dcnt_q - DLY_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dcnt_q <= '0;
      hi_q   <= '1;
      last_q <= '1;
    end else begin
      st_q   <= st_d;
      dcnt_q <= dcnt_d;
      hi_q   <= hi_d;
      last_q <= last_d;
    end
  end

  assign st   = st_q;
  assign ack  = (st_q == ST_RUN);
  assign idle = (st_q == ST_IDLE) && gap_ok;
endmodule

// File: rtl/qspi_cs_timer.sv
module qspi_cs_timer
  import qct_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int DIV_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_dec,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [DLY_W-1:0] dly_setup,
  input  logic [DLY_W-1:0] dly_hold,
  input  logic [DLY_W-1:0] dly_d2d,
  input  logic [DLY_W-1:0] dly_minhi,
  input  logic             frm_req,
  output logic             frm_ack,
  output logic             sclk,
  output logic [SEL_W-1:0] cs_n,
  output logic             idle
);
  localparam int CFG_W = 3 + SEL_W + DIV_W;

  logic             rst_s1, rst_s2;
  logic             cpol_q, cpha_q, dec_q;
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] pat;
  logic [CFG_W-1:0] shadow_bus;
  qct_state_e       st;
  logic             run_start, tick_en, ph, load;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  assign load = !cfg_en && (st == ST_IDLE);

  qct_shadow #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_shadow (
    .clk(clk), .rst_n(rst_s2), .load(load),
    .cpol_i(cfg_cpol), .cpha_i(cfg_cpha), .dec_i(cfg_dec),
    .sel_i(cfg_sel), .div_i(cfg_div),
    .cpol_q(cpol_q), .cpha_q(cpha_q), .dec_q(dec_q),
    .sel_q(sel_q), .div_q(div_q)
  );

  qct_fsm #(.SEL_W(SEL_W), .DLY_W(DLY_W)) u_fsm (
    .clk(clk), .rst_n(rst_s2), .en(cfg_en), .req(frm_req), .ph(ph),
    .pat(pat), .d_setup(dly_setup), .d_hold(dly_hold),
    .d_d2d(dly_d2d), .d_minhi(dly_minhi),
    .st(st), .run_start(run_start), .tick_en(tick_en),
    .ack(frm_ack), .idle(idle)
  );

  qct_sclk #(.DIV_W(DIV_W)) u_sclk (
    .clk(clk), .rst_n(rst_s2), .start(run_start), .tick_en(tick_en),
    .cpha(cpha_q), .div(div_q), .ph(ph)
  );

  qct_cs_enc #(.SEL_W(SEL_W)) u_enc (
    .active(st != ST_IDLE), .dec(dec_q), .sel(sel_q),
    .pat(pat), .cs_n(cs_n)
  );

  assign sclk       = cpol_q ^ ph;
  assign shadow_bus = {cpol_q, cpha_q, dec_q, sel_q, div_q};
endmodule

// File: rtl/qct_chk.sv
module qct_chk
  import qct_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int CFG_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input qct_state_e       st,
  input logic             frm_ack,
  input logic             sclk,
  input logic             cpol_q,
  input logic             dec_q,
  input logic             idle,
  input logic [SEL_W-1:0] cs_n,
  input logic [CFG_W-1:0] cfg_bus
);
  // R11: latched configuration cannot move once a frame is open
  p_frozen_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> $stable(cfg_bus));

  // R5: clock parked at polarity outside the running state
  p_parked_sclk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_RUN) |-> (sclk == cpol_q));

  // R7: acknowledge only drops with the clock at its idle level
  p_fall_at_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frm_ack) |-> (sclk == cpol_q));

  // R2: direct mode selects exactly one line
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st != ST_IDLE) && !dec_q) |-> ($countones(cs_n) == SEL_W - 1));

  // R12: idle implies nothing selected and no running clock
  p_idle_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> ((cs_n == '1) && !frm_ack && (st == ST_IDLE)));

  // R2: select lines hold steady while the clock runs
  p_cs_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_ack && $past(frm_ack)) |-> $stable(cs_n));
endmodule

bind qspi_cs_timer qct_chk #(.SEL_W(SEL_W), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .frm_ack(frm_ack), .sclk(sclk),
  .cpol_q(cpol_q), .dec_q(dec_q), .idle(idle), .cs_n(cs_n),
  .cfg_bus(shadow_bus)
);

// File: tb/qspi_cs_timer_bench.sv
module qspi_cs_timer_bench;
  localparam int LIM = 2000;

  logic       clk, rst_n;
  logic       cfg_en, cfg_cpol, cfg_cpha, cfg_dec;
  logic [3:0] cfg_sel, cfg_div;
  logic [7:0] ds, dh, dd, dm;
  logic       frm_req;
  logic       frm_ack, sclk, idle;
  logic [3:0] cs_n;

  logic       cur_cpol, cur_cpha, cur_dec;
  logic [3:0] cur_sel, cur_div;
  bit         pend_en;
  int         checks, fails;

  qspi_cs_timer u_qspi_cs_timer (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_dec(cfg_dec), .cfg_sel(cfg_sel),
    .cfg_div(cfg_div), .dly_setup(ds), .dly_hold(dh), .dly_d2d(dd),
    .dly_minhi(dm), .frm_req(frm_req), .frm_ack(frm_ack), .sclk(sclk),
    .cs_n(cs_n), .idle(idle)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [3:0] exp_pat(input logic d, input logic [3:0] s);
    logic [3:0] p;
    p = 4'hF;
    if (d) p = s;
    else p[s[1:0]] = 1'b0;
    return p;
  endfunction

  task automatic set_cfg(input logic p, input logic h, input logic dcd,
                         input logic [3:0] s, input logic [3:0] n);
    cfg_en = 1'b0; frm_req = 1'b0;
    cfg_cpol = p; cfg_cpha = h; cfg_dec = dcd; cfg_sel = s; cfg_div = n;
    cur_cpol = p; cur_cpha = h; cur_dec = dcd; cur_sel = s; cur_div = n;
    step(); step();
    cfg_en = 1'b1;
    step();
    chk(sclk === p, "R5 idle level", sclk, p);
  endtask

  task automatic wait_idle();
    int c;
    c = 0;
    while (!idle && c < LIM) begin c++; step(); end
  endtask

  // One full frame; ends on the first sample with chip select released.
  task automatic run_frame(input int ntog, input int gap_exp, input string gtag,
                           input bit chained, input bit next_req, input int new_sel);
    int cnt, idx, last_i, tg, n;
    logic prev;
    logic [3:0] pat;
    bit bad;
    n = cur_div;
    pat = exp_pat(cur_dec, cur_sel);
    if (chained) cnt = 1;
    else begin cnt = 0; frm_req = 1'b1; end
    step();
    if (pend_en) begin cfg_en = 1'b1; pend_en = 1'b0; end
    while (cs_n === 4'hF && cnt < LIM) begin cnt++; step(); end
    if (gap_exp >= 0) chk(cnt == gap_exp, gtag, cnt, gap_exp);
    chk(cs_n === pat, cur_dec ? "R3 code" : "R2 pattern", cs_n, pat);
    chk(idle === 1'b0, "R12 busy", idle, 0);
    // setup interval
    cnt = 0; bad = 0;
    while (!frm_ack && cnt < LIM) begin
      if (sclk !== cur_cpol) bad = 1;
      cnt++; step();
    end
    chk(cnt == mx(ds, 1), "R4 setup", cnt, mx(ds, 1));
    chk(!bad, "R5 parked in setup", bad, 0);
    // running clock
    idx = 0; last_i = 0; tg = 0; prev = sclk; bad = 0;
    while (tg < ntog && idx < LIM) begin
      step(); idx++;
      if (!frm_ack || cs_n !== pat) bad = 1;
      if (sclk !== prev) begin
        tg++;
        if (tg == 1) chk(idx == (cur_cpha ? 1 : n + 1), "R6 first edge", idx, cur_cpha ? 1 : n + 1);
        else chk(idx - last_i == n + 1, "R5 half period", idx - last_i, n + 1);
        last_i = idx; prev = sclk;
      end
    end
    chk(!bad, "R2 steady select", bad, 0);
    frm_req = 1'b0;
    cnt = 0;
    do begin step(); cnt++; end while (frm_ack && cnt < LIM);
    chk(cnt == ((ntog % 2 == 0) ? 1 : n + 2), "R7 stop", cnt, (ntog % 2 == 0) ? 1 : n + 2);
    chk(sclk === cur_cpol, "R7 idle at stop", sclk, cur_cpol);
    frm_req = next_req;
    // hold interval
    cnt = 1; bad = 0;
    step();
    while (cs_n !== 4'hF && cnt < LIM) begin
      if (sclk !== cur_cpol || frm_ack) bad = 1;
      cnt++; step();
    end
    chk(cnt == mx(dh, 1), "R8 hold", cnt, mx(dh, 1));
    chk(!bad, "R8 quiet hold", bad, 0);
    if (new_sel >= 0) begin
      cfg_en = 1'b0; cfg_sel = 4'(new_sel); cur_sel = 4'(new_sel); pend_en = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int c;
    checks = 0; fails = 0; pend_en = 0;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_cpol = 0; cfg_cpha = 0; cfg_dec = 0;
    cfg_sel = 0; cfg_div = 0; ds = 0; dh = 0; dd = 0; dm = 0; frm_req = 0;
    cur_cpol = 0; cur_cpha = 0; cur_dec = 0; cur_sel = 0; cur_div = 0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    // R1 reset state
    chk(cs_n === 4'hF, "R1 cs", cs_n, 15);
    chk(sclk === 1'b0, "R1 sclk", sclk, 0);
    chk(frm_ack === 1'b0, "R1 ack", frm_ack, 0);
    chk(idle === 1'b1, "R1 idle", idle, 1);

    // R11: no frame while disabled
    frm_req = 1'b1;
    repeat (8) step();
    chk(cs_n === 4'hF, "R11 disabled cs", cs_n, 15);
    chk(frm_ack === 1'b0, "R11 disabled ack", frm_ack, 0);
    frm_req = 1'b0;

    // R4..R9 sweep over polarity, phase and divisor
    for (int p = 0; p < 2; p++)
      for (int h = 0; h < 2; h++)
        for (int d = 0; d < 4; d++) begin
          ds = 8'(d); dh = 8'(3 - d); dm = 8'(d + 1); dd = 8'd0;
          set_cfg(p[0], h[0], 1'b0, 4'(d + p), 4'(d));
          run_frame(2, -1, "R9", 0, 1, -1);
          run_frame(3, mx(d + 1, 1), "R9 same device gap", 1, 0, -1);
          wait_idle();
        end

    // R3 decoder codes and R2 upper bits ignored
    ds = 1; dh = 1; dm = 1; dd = 0;
    for (int s = 0; s < 15; s++) begin
      set_cfg(1'b0, 1'b0, 1'b1, 4'(s), 4'd1);
      run_frame(2, -1, "R3", 0, 0, -1);
      chk(cs_n === 4'hF, "R3 released", cs_n, 15);
    end
    set_cfg(1'b0, 1'b1, 1'b0, 4'b0110, 4'd0);
    run_frame(2, -1, "R2", 0, 0, -1);
    wait_idle();

    // R10 device change, R9 same device ignores d2d
    ds = 2; dh = 2; dm = 2; dd = 6;
    set_cfg(1'b1, 1'b1, 1'b0, 4'd0, 4'd0);
    run_frame(2, -1, "R10", 0, 1, 1);
    run_frame(2, mx(6, 2), "R10 change gap", 1, 1, -1);
    run_frame(2, 2, "R9 d2d ignored", 1, 1, 3);
    dm = 5; dd = 3;
    run_frame(2, mx(5, 2), "R10 minhi larger", 1, 0, -1);
    wait_idle();

    // R12 idle waits out the released time
    dm = 7; dd = 0;
    run_frame(2, -1, "R12", 0, 0, -1);
    c = 0;
    while (!idle && c < LIM) begin c++; step(); end
    chk(c == 6, "R12 released time", c, 6);

    // R11 changes while enabled are ignored
    cfg_cpol = ~cur_cpol; cfg_sel = cur_sel + 4'd1; cfg_div = 4'd3;
    repeat (3) step();
    chk(sclk === cur_cpol, "R11 polarity held", sclk, cur_cpol);
    run_frame(2, -1, "R11", 0, 0, -1);
    wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule